// File: doc/BRIEF.md
# Posted Write Buffer for Peripheral Regions

This block sits between a requester and a peripheral port and holds writes aimed at device-type address ranges. Each write arrives with three attribute bits. The gather bit allows the write to be combined with a neighbouring write. The reorder bit allows a later write to be issued ahead of it. The early bit selects when its completion is reported: as soon as the buffer takes the write, or only after the peripheral has taken it.

The queue holds up to four writes, kept in age order, with one further write in the downstream output register. A write is folded into the youngest queued entry only when all of these hold: both writes allow gathering, both fall in the same aligned data word, and the incoming write asks for early completion. Every accepted write receives a wrapping sequence tag, and that tag returns on the completion channel. The issue picker always treats a write that disallows reordering as a barrier. Inside a run of reorder-tolerant writes at the head of the queue, it sends the oldest write whose requester is still waiting for a late completion.

Top module: `devw_buffer`

## Requirements
- R1: After reset the block presents no downstream request and no completion, and it can accept a write.
- R2: Once four writes are queued behind the one held downstream, `req_ready` is low and no further write is accepted.
- R3: A write whose gather bit is 0 reaches the downstream port as its own access, with its address, data and strobes unchanged.
- R4: An incoming write merges into the youngest queued entry only if both have the gather bit set, both addresses match above the byte-lane bits, and the incoming early bit is 1. In the merged entry, lanes strobed by the new write take its bytes, all other lanes keep the old bytes, and the strobes are ORed together.
- R5: Writes that allow gathering but address different words stay separate accesses.
- R6: A write with reorder bit 0 is never passed by a younger write, and never passes an older one.
- R7: Within the run of reorder-tolerant entries that begins at the oldest entry, the oldest entry with early bit 0 is issued first. If that run holds no such entry, the oldest entry is issued.
- R8: A write with early bit 1 produces its completion in the cycle right after its acceptance handshake.
- R9: A write with early bit 0 produces its completion in the cycle right after its downstream handshake (`dn_valid` and `dn_ack` both high).
- R10: The completion tag equals the write's arrival count modulo 2^TAG_W, counted from 0 after reset. Merged writes count as arrivals.
- R11: While `dn_valid` is high and `dn_ack` is low, the downstream address, data and strobes stay constant.
- R12: `req_ready` is low in any cycle in which a late-completing write finishes its downstream handshake, so two completions never compete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Buffer can take the write this cycle |
| req_addr | input | ADDR_W | Byte address of the write |
| req_data | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Byte lane enables |
| req_gather | input | 1 | Write may be combined with others |
| req_reorder | input | 1 | Write may be overtaken or overtake |
| req_early | input | 1 | Report completion on acceptance |
| cpl_valid | output | 1 | Completion pulse |
| cpl_tag | output | TAG_W | Tag of the completed write |
| dn_valid | output | 1 | Downstream access presented |
| dn_addr | output | ADDR_W | Downstream address |
| dn_data | output | DATA_W | Downstream data |
| dn_strb | output | DATA_W/8 | Downstream byte lanes |
| dn_ack | input | 1 | Peripheral takes the presented access |

## Verification
An early completion is due one clock after the edge that accepted the write. A late completion is due one clock after the edge that carried its downstream handshake. A queued write moves into the downstream register on the first edge at which that register is empty or being acknowledged. The bench logs the cycle number of every acceptance, every downstream handshake and every completion, sampled on the clock edge. It then compares each completion's cycle against the logged cycle of its trigger plus one, so no check depends on a guessed absolute time. Port levels such as ready, together with the held payload, are read mid-cycle at the falling edge.

// File: rtl/devwb_pkg.sv
`timescale 1ns/1ps
package devwb_pkg;

  typedef struct packed {
    logic gather;
    logic reorder;
    logic early;
  } dev_attr_t;

  // Attributes of an entry after a younger write is folded into it:
  // the entry keeps its own completion timing, ordering takes the stricter.
  function automatic dev_attr_t attr_fold(dev_attr_t held, dev_attr_t incoming);
    dev_attr_t r;
    r.gather  = held.gather & incoming.gather;
    r.reorder = held.reorder & incoming.reorder;
    r.early   = held.early;
    return r;
  endfunction

endpackage

// File: rtl/devwb_pick.sv
`timescale 1ns/1ps
module devwb_pick #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [CNT_W-1:0] count,
  input  logic [DEPTH-1:0] reorder_ok,
  input  logic [DEPTH-1:0] early_ok,
  output logic [IDX_W-1:0] sel
);

  logic stop;

  always_comb begin
    sel  = '0;
    stop = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!stop && (i < int'(count))) begin
        if (!reorder_ok[i]) begin
          stop = 1'b1;
        end else if (!early_ok[i]) begin
          sel  = IDX_W'(i);
          stop = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/devwb_merge.sv
`timescale 1ns/1ps
module devwb_merge #(
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_data,
  input  logic [STRB_W-1:0] old_strb,
  input  logic [DATA_W-1:0] new_data,
  input  logic [STRB_W-1:0] new_strb,
  output logic [DATA_W-1:0] out_data,
  output logic [STRB_W-1:0] out_strb
);

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign out_data[b*8 +: 8] = new_strb[b] ? new_data[b*8 +: 8] : old_data[b*8 +: 8];
  end

  assign out_strb = old_strb | new_strb;

endmodule

// File: rtl/devw_buffer.sv
`timescale 1ns/1ps
module devw_buffer
  import devwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_data,
  input  logic [DATA_W/8-1:0]    req_strb,
  input  logic                   req_gather,
  input  logic                   req_reorder,
  input  logic                   req_early,
  output logic                   cpl_valid,
  output logic [TAG_W-1:0]       cpl_tag,
  output logic                   dn_valid,
  output logic [ADDR_W-1:0]      dn_addr,
  output logic [DATA_W-1:0]      dn_data,
  output logic [DATA_W/8-1:0]    dn_strb,
  input  logic                   dn_ack
);

  localparam int STRB_W = DATA_W / 8;
  localparam int LSB    = $clog2(STRB_W);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = $clog2(DEPTH);

  // Age-ordered queue, slot 0 oldest
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [STRB_W-1:0] q_strb [DEPTH];
  dev_attr_t         q_attr [DEPTH];
  logic [TAG_W-1:0]  q_tag  [DEPTH];
  logic [CNT_W-1:0]  q_count;

  logic [ADDR_W-1:0] n_addr [DEPTH];
  logic [DATA_W-1:0] n_data [DEPTH];
  logic [STRB_W-1:0] n_strb [DEPTH];
  dev_attr_t         n_attr [DEPTH];
  logic [TAG_W-1:0]  n_tag  [DEPTH];
  logic [CNT_W-1:0]  n_count;

  logic              dn_early;
  logic [TAG_W-1:0]  dn_tag;
  logic [TAG_W-1:0]  tag_ctr;

  dev_attr_t         req_attr;
  logic [DEPTH-1:0]  re_vec, ea_vec;
  logic [IDX_W-1:0]  sel_idx, young_idx, fold_idx, put_idx;
  logic [DATA_W-1:0] mg_data;
  logic [STRB_W-1:0] mg_strb;
  logic [CNT_W-1:0]  fill;
  logic              issue, late_done, accept, merge_ok;

  assign req_attr = '{gather: req_gather, reorder: req_reorder, early: req_early};

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      re_vec[i] = q_attr[i].reorder;
      ea_vec[i] = q_attr[i].early;
    end
  end

  devwb_pick #(.DEPTH(DEPTH)) u_pick (
    .count      (q_count),
    .reorder_ok (re_vec),
    .early_ok   (ea_vec),
    .sel        (sel_idx)
  );

  assign young_idx = IDX_W'(q_count - CNT_W'(1));

  devwb_merge #(.DATA_W(DATA_W)) u_merge (
    .old_data (q_data[young_idx]),
    .old_strb (q_strb[young_idx]),
    .new_data (req_data),
    .new_strb (req_strb),
    .out_data (mg_data),
    .out_strb (mg_strb)
  );

  assign issue     = (q_count != '0) && (!dn_valid || dn_ack);
  assign late_done = dn_valid && dn_ack && !dn_early;
  assign req_ready = (q_count != CNT_W'(DEPTH)) && !late_done;
  assign accept    = req_valid && req_ready;
  assign merge_ok  = accept && (q_count != '0) && req_gather && req_early
                   && q_attr[young_idx].gather
                   && (q_addr[young_idx][ADDR_W-1:LSB] == req_addr[ADDR_W-1:LSB])
                   && !(issue && (sel_idx == young_idx));

  // Next-state of the queue: compaction on issue, then fold or append
  always_comb begin
    n_addr = q_addr;
    n_data = q_data;
    n_strb = q_strb;
    n_attr = q_attr;
    n_tag  = q_tag;
    fill   = q_count;
    if (issue) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(sel_idx)) begin
          n_addr[i] = q_addr[i+1];
          n_data[i] = q_data[i+1];
          n_strb[i] = q_strb[i+1];
          n_attr[i] = q_attr[i+1];
          n_tag[i]  = q_tag[i+1];
        end
      end
      fill = q_count - CNT_W'(1);
    end
    fold_idx = IDX_W'(fill - CNT_W'(1));
    put_idx  = IDX_W'(fill);
    if (merge_ok) begin
      n_data[fold_idx] = mg_data;
      n_strb[fold_idx] = mg_strb;
      n_attr[fold_idx] = attr_fold(q_attr[young_idx], req_attr);
    end else if (accept) begin
      n_addr[put_idx] = req_addr;
      n_data[put_idx] = req_data;
      n_strb[put_idx] = req_strb;
      n_attr[put_idx] = req_attr;
      n_tag[put_idx]  = tag_ctr;
      fill = fill + CNT_W'(1);
    end
    n_count = fill;
  end

  // Payload storage, no reset
  always_ff @(posedge clk) begin
    q_addr <= n_addr;
    q_data <= n_data;
    q_strb <= n_strb;
    q_attr <= n_attr;
    q_tag  <= n_tag;
    if (issue) begin
      dn_addr  <= q_addr[sel_idx];
      dn_data  <= q_data[sel_idx];
      dn_strb  <= q_strb[sel_idx];
      dn_early <= q_attr[sel_idx].early;
      dn_tag   <= q_tag[sel_idx];
    end
    cpl_tag <= late_done ? dn_tag : tag_ctr;
  end

  // Control state
  always_ff @(posedge clk) begin
    if (rst) begin
      q_count   <= '0;
      dn_valid  <= 1'b0;
      cpl_valid <= 1'b0;
      tag_ctr   <= '0;
    end else begin
      q_count   <= n_count;
      cpl_valid <= late_done || (accept && req_early);
      if (accept) tag_ctr <= tag_ctr + TAG_W'(1);
      if (issue) dn_valid <= 1'b1;
      else if (dn_ack) dn_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/devwb_chk.sv
`timescale 1ns/1ps
module devwb_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_early,
  input logic                cpl_valid,
  input logic                dn_valid,
  input logic                dn_ack,
  input logic                dn_early,
  input logic [ADDR_W-1:0]   dn_addr,
  input logic [DATA_W-1:0]   dn_data,
  input logic [DATA_W/8-1:0] dn_strb,
  input logic [CNT_W-1:0]    q_count
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dn_valid && !cpl_valid));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH));

  assert_early_cpl_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_early) |=> cpl_valid);

  assert_late_cpl_R9: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_ack && !dn_early) |=> cpl_valid);

  assert_dn_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_addr) && $stable(dn_data) && $stable(dn_strb)));

endmodule

bind devw_buffer devwb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_early (req_early),
  .cpl_valid (cpl_valid),
  .dn_valid  (dn_valid),
  .dn_ack    (dn_ack),
  .dn_early  (dn_early),
  .dn_addr   (dn_addr),
  .dn_data   (dn_data),
  .dn_strb   (dn_strb),
  .q_count   (q_count)
);

// File: tb/tb_devw_buffer.sv
`timescale 1ns/1ps
module tb_devw_buffer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [3:0]  req_strb = '0;
  logic        req_gather = 1'b0, req_reorder = 1'b0, req_early = 1'b0;
  logic        cpl_valid;
  logic [2:0]  cpl_tag;
  logic        dn_valid;
  logic [31:0] dn_addr, dn_data;
  logic [3:0]  dn_strb;
  logic        ack_en = 1'b0;
  logic        dn_ack;

  assign dn_ack = ack_en;

  always #4 clk = ~clk;

  devw_buffer dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_strb(req_strb), .req_gather(req_gather),
    .req_reorder(req_reorder), .req_early(req_early),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_data(dn_data),
    .dn_strb(dn_strb), .dn_ack(dn_ack)
  );

  // Event logs written only by the monitor
  int          cyc = 0;
  logic [31:0] dn_a [64];
  logic [31:0] dn_d [64];
  logic [3:0]  dn_s [64];
  int          dn_c [64];
  int          cp_t [64];
  int          cp_c [64];
  int          ac_c [64];
  int          n_dn = 0, n_cp = 0, n_ac = 0;

  always @(posedge clk) begin
    if (!rst) begin
      if (req_valid && req_ready && n_ac < 64) begin
        ac_c[n_ac] = cyc; n_ac = n_ac + 1;
      end
      if (dn_valid && dn_ack && n_dn < 64) begin
        dn_a[n_dn] = dn_addr; dn_d[n_dn] = dn_data; dn_s[n_dn] = dn_strb;
        dn_c[n_dn] = cyc; n_dn = n_dn + 1;
      end
      if (cpl_valid && n_cp < 64) begin
        cp_t[n_cp] = int'(cpl_tag); cp_c[n_cp] = cyc; n_cp = n_cp + 1;
      end
    end
    cyc = cyc + 1;
  end

  int n_chk = 0, n_fail = 0, exp_tag = 0;
  int db, cb, ab, t0;

  task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                      input logic g, input logic r, input logic e);
    req_addr = a; req_data = d; req_strb = s;
    req_gather = g; req_reorder = r; req_early = e;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    exp_tag++;
  endtask

  task automatic drain();
    ack_en = 1'b1;
    @(negedge clk);
    while (dn_valid) @(negedge clk);
    ack_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic mark();
    db = n_dn; cb = n_cp; ab = n_ac; t0 = exp_tag;
  endtask

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog run did not end actual=timeout expected=done");
    summary_and_end();
  end

  logic [31:0] held;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    check("R1", "dn_valid", dn_valid, 0);
    check("R1", "cpl_valid", cpl_valid, 0);
    check("R1", "req_ready", req_ready, 1);
    @(negedge clk);

    // Test A: non-gathering, strict, late writes to one word
    mark();
    for (int i = 0; i < 5; i++) push(32'h10, 32'hA000_0000 + i, 4'b0001 << (i % 4), 0, 0, 0);
    #1;
    check("R2", "ready with full queue", req_ready, 0);
    held = dn_data;
    @(negedge clk); #1;
    check("R11", "dn_valid held", dn_valid, 1);
    check("R11", "dn_data held", dn_data, held);
    check("R2", "no extra accept", n_ac - ab, 5);
    ack_en = 1'b1;
    @(negedge clk); #1;
    check("R12", "ready low on late handshake", req_ready, 0);
    push(32'h10, 32'hA000_0005, 4'b0010, 0, 0, 0);
    drain();
    check("R3", "access count", n_dn - db, 6);
    for (int i = 0; i < 6; i++) begin
      check("R3", "addr", dn_a[db+i], 32'h10);
      check("R6", "arrival order data", dn_d[db+i], 32'hA000_0000 + i);
      check("R3", "strobes", dn_s[db+i], 4'b0001 << (i % 4));
    end
    check("R9", "completion count", n_cp - cb, 6);
    for (int i = 0; i < 6; i++) begin
      check("R10", "tag", cp_t[cb+i], (t0 + i) % 8);
      check("R9", "late completion cycle", cp_c[cb+i], dn_c[db+i] + 1);
    end

    // Test B: gathering
    mark();
    push(32'h80, 32'hB0B0_B0B0, 4'hF, 0, 0, 1);
    push(32'h20, 32'h1111_11AA, 4'h1, 1, 0, 1);
    push(32'h20, 32'h2222_BB22, 4'h2, 1, 0, 1);
    push(32'h20, 32'h3333_33CC, 4'h1, 1, 0, 1);
    push(32'h24, 32'h4444_4444, 4'h4, 1, 0, 1);
    push(32'h24, 32'h5555_5555, 4'h2, 1, 0, 0);
    drain();
    check("R4", "access count after merge", n_dn - db, 4);
    check("R3", "blocker addr", dn_a[db], 32'h80);
    check("R4", "merged addr", dn_a[db+1], 32'h20);
    check("R4", "merged data", dn_d[db+1], 32'h1111_BBCC);
    check("R4", "merged strobes", dn_s[db+1], 4'h3);
    check("R5", "other word addr", dn_a[db+2], 32'h24);
    check("R5", "other word data", dn_d[db+2], 32'h4444_4444);
    check("R4", "late write not merged data", dn_d[db+3], 32'h5555_5555);
    check("R4", "late write not merged strb", dn_s[db+3], 4'h2);
    check("R8", "completion count", n_cp - cb, 6);
    for (int i = 0; i < 5; i++) begin
      check("R10", "tag", cp_t[cb+i], (t0 + i) % 8);
      check("R8", "early completion cycle", cp_c[cb+i], ac_c[ab+i] + 1);
    end
    check("R10", "late tag", cp_t[cb+5], (t0 + 5) % 8);
    check("R9", "late completion cycle", cp_c[cb+5], dn_c[db+3] + 1);

    // Test D: reordering among tolerant entries
    mark();
    push(32'h80, 32'hC000_0000, 4'hF, 0, 0, 1);
    push(32'h40, 32'hC000_0001, 4'hF, 0, 1, 1);
    push(32'h44, 32'hC000_0002, 4'hF, 0, 1, 0);
    push(32'h48, 32'hC000_0003, 4'hF, 0, 0, 0);
    push(32'h4C, 32'hC000_0004, 4'hF, 0, 1, 0);
    drain();
    check("R7", "access count", n_dn - db, 5);
    check("R7", "slot0", dn_a[db+0], 32'h80);
    check("R7", "late write passes", dn_a[db+1], 32'h44);
    check("R7", "early write next", dn_a[db+2], 32'h40);
    check("R6", "strict stays", dn_a[db+3], 32'h48);
    check("R6", "not passing strict", dn_a[db+4], 32'h4C);
    check("R8", "completion count", n_cp - cb, 5);
    check("R8", "early cycle first", cp_c[cb+0], ac_c[ab+0] + 1);
    check("R8", "early cycle second", cp_c[cb+1], ac_c[ab+1] + 1);
    check("R10", "tag P1", cp_t[cb+2], (t0 + 2) % 8);
    check("R9", "cycle P1", cp_c[cb+2], dn_c[db+1] + 1);
    check("R10", "tag P2", cp_t[cb+3], (t0 + 3) % 8);
    check("R9", "cycle P2", cp_c[cb+3], dn_c[db+3] + 1);
    check("R10", "tag P3", cp_t[cb+4], (t0 + 4) % 8);
    check("R9", "cycle P3", cp_c[cb+4], dn_c[db+4] + 1);

    // Test E: strict late write behind tolerant early write
    mark();
    push(32'h80, 32'hD000_0000, 4'hF, 0, 0, 1);
    push(32'h50, 32'hD000_0001, 4'hF, 0, 1, 1);
    push(32'h54, 32'hD000_0002, 4'hF, 0, 0, 0);
    drain();
    check("R6", "access count", n_dn - db, 3);
    check("R6", "older first", dn_a[db+1], 32'h50);
    check("R6", "strict second", dn_a[db+2], 32'h54);
    check("R9", "strict late cycle", cp_c[cb+2], dn_c[db+2] + 1);
    check("R10", "strict late tag", cp_t[cb+2], (t0 + 2) % 8);

    summary_and_end();
  end

endmodule